// File: doc/BRIEF.md
# Adaptive Coherence Cache-Cell Controller

This block sits on the cache side of a coherence fabric and manages a small, direct-mapped set of cache cells. Each cell is either uncached or holds one line. A held line records which of three coherence sub-protocols governs it (Base, Write-Pass or Migratory), whether it is clean or dirty, and whether a writeback is still outstanding. Processor instructions arrive on a ready/valid queue. An instruction leaves the queue only in the cycle the cell permits it, and a data word or an acknowledgment is returned on the same cycle. Instructions that are not yet permitted wait at the head of the queue.

Memory messages arrive on a second queue and are consumed in the cycle they are handled. These messages install lines, acknowledge writebacks and demote a line's sub-protocol. A third queue carries eviction requests, which either drop a clean Base line or send a dirty Base line back to memory. Outgoing coherence traffic leaves on a fourth ready/valid port. At most one of the three inputs acts per cycle: memory messages first, evictions second, instructions last.

Top module: `coh_cell_ctrl`

## Requirements
- R1: A load (op 0) retires only when the address hits a valid line whose writeback is not pending, under any sub-protocol, and the reply carries `rep_is_data`=1 with the line's data. Cell index is `addr[2:0]` and tag is `addr[5:3]`. A miss, including a different tag at the same index, keeps the load waiting.
- R2: A store (op 1) retires only on a hit under any sub-protocol. It replaces the line's data and marks the line dirty. The reply is an acknowledgment (`rep_is_data`=0).
- R3: A commit (op 2) retires when the address is uncached, or the line is clean, or the line is dirty under Migratory (code 2). A dirty line under Base (code 0) or Write-Pass (code 1) holds the commit.
- R4: A reconcile (op 3) retires when the address is uncached, or the line is dirty, or the line is clean under Write-Pass or Migratory. A clean Base line holds the reconcile.
- R5: An instruction retires (`ins_ready`=1) only in a cycle where `rep_valid` and `rep_ready` are both high. A held instruction leaves cell contents unchanged.
- R6: An eviction request on a clean Base line leaves the address uncached and sends nothing. On a line that is not Base, on a miss, or on a line with a pending writeback, the request is consumed with no effect.
- R7: An eviction on a dirty Base line emits an outgoing writeback (kind 0) carrying the line's data and marks the line pending. Every instruction to that address is then held until a writeback acknowledgment (message kind 1) turns the line into clean Base.
- R8: While a memory message is valid, no eviction or instruction is accepted. While an eviction is valid, no instruction is accepted.
- R9: A Migratory-to-Write-Pass demotion (message kind 2) on a Migratory line leaves it clean Write-Pass. It emits a data-carrying reply (kind 2) if the line was dirty, else an acknowledgment (kind 1). On any other line it is consumed silently.
- R10: A Write-Pass-to-Base demotion (message kind 3) on a Write-Pass line changes only the sub-protocol to Base and keeps dirtiness. It emits an acknowledgment (kind 1). On any other line it is consumed silently.
- R11: A Migratory-to-Base demotion (message kind 4) yields the same line state as kind 2 followed by kind 3: clean Base. It emits one reply, data-carrying (kind 2) if the line was dirty, else an acknowledgment. On a miss it is consumed silently.
- R12: A fill message (kind 0) installs the addressed line as clean under the sub-protocol given in `mem_proto`, with data from `mem_data`.
- R13: After reset every cell is uncached. Loads wait, commits and reconciles retire, and `out_valid` is low while no message or eviction is offered.
- R14: A memory message or eviction that must emit outgoing traffic is not accepted while `out_ready` is low. `out_valid` is still raised for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction at queue head |
| ins_ready | output | 1 | Instruction retired this cycle |
| ins_op | input | 2 | 0 load, 1 store, 2 commit, 3 reconcile |
| ins_addr | input | ADDR_W | Instruction address |
| ins_wdata | input | DATA_W | Store data |
| rep_valid | output | 1 | Reply offered (instruction permitted) |
| rep_ready | input | 1 | Reply queue can take a reply |
| rep_is_data | output | 1 | Reply is a data word (load) |
| rep_data | output | DATA_W | Load data |
| mem_valid | input | 1 | Memory message offered |
| mem_ready | output | 1 | Memory message consumed this cycle |
| mem_kind | input | 3 | 0 fill, 1 writeback ack, 2 M-to-W, 3 W-to-B, 4 M-to-B |
| mem_addr | input | ADDR_W | Message address |
| mem_proto | input | 2 | Sub-protocol for a fill: 0 Base, 1 Write-Pass, 2 Migratory |
| mem_data | input | DATA_W | Fill data |
| ev_valid | input | 1 | Eviction request offered |
| ev_ready | output | 1 | Eviction request consumed |
| ev_addr | input | ADDR_W | Eviction address |
| out_valid | output | 1 | Outgoing message offered |
| out_ready | input | 1 | Outgoing queue can take a message |
| out_kind | output | 2 | 0 writeback, 1 demotion ack, 2 demotion with data |
| out_addr | output | ADDR_W | Outgoing message address |
| out_data | output | DATA_W | Outgoing data |

## Verification
The hardest situation to reach from the ports is the writeback window. A line must first be filled as Base, then dirtied by a store, then evicted. Only then can the bench show that loads and commits are held, and that the writeback acknowledgment returns the line as clean Base with its data intact. The stimulus table walks through that sequence on one address. It runs a parallel chain on Migratory lines to compare the composite demotion with the two single-step demotions, for both dirty and clean lines. Directed tests then present two channels in the same cycle and withhold `out_ready` or `rep_ready`, to reach the priority and back-pressure cases.

// File: rtl/coh_pkg.sv
package coh_pkg;
  localparam logic [1:0] P_BASE = 2'd0;
  localparam logic [1:0] P_WP   = 2'd1;
  localparam logic [1:0] P_MIG  = 2'd2;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_COMMIT = 2'd2;
  localparam logic [1:0] OP_RECON = 2'd3;

  localparam logic [2:0] MK_FILL  = 3'd0;
  localparam logic [2:0] MK_WBACK = 3'd1;
  localparam logic [2:0] MK_DN_MW = 3'd2;
  localparam logic [2:0] MK_DN_WB = 3'd3;
  localparam logic [2:0] MK_DN_MB = 3'd4;

  localparam logic [1:0] OK_WBB = 2'd0;
  localparam logic [1:0] OK_ACK = 2'd1;
  localparam logic [1:0] OK_VAL = 2'd2;

  typedef struct packed {
    logic       valid;
    logic [1:0] proto;
    logic       dirty;
    logic       wbp;
  } cst_t;

  // Whether an instruction may retire on a line, given hit and line state.
  function automatic logic op_permit(logic [1:0] op, logic hit, cst_t c);
    logic ok;
    if (hit && c.wbp) ok = 1'b0;
    else begin
      case (op)
        OP_LOAD, OP_STORE: ok = hit;
        OP_COMMIT: ok = !hit || !c.dirty || (c.proto == P_MIG);
        default:   ok = !hit || c.dirty || (c.proto != P_BASE);
      endcase
    end
    return ok;
  endfunction

  // One demotion step; a step into Write-Pass flushes dirtiness upward.
  function automatic cst_t demote(cst_t c, logic [1:0] to);
    cst_t n;
    n = c;
    n.proto = to;
    n.dirty = (to == P_BASE && c.proto == P_WP) ? c.dirty : 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/coh_lookup.sv
module coh_lookup
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic [ADDR_W-1:0]                       addr,
  input  cst_t [(1<<IDX_W)-1:0]                    st,
  input  logic [(1<<IDX_W)-1:0][ADDR_W-IDX_W-1:0]  tags,
  input  logic [(1<<IDX_W)-1:0][DATA_W-1:0]        dat,
  output logic                                    match,
  output cst_t                                    cur,
  output logic [DATA_W-1:0]                       cur_data
);
  logic [IDX_W-1:0] ix;
  assign ix       = addr[IDX_W-1:0];
  assign cur      = st[ix];
  assign cur_data = dat[ix];
  assign match    = st[ix].valid && (tags[ix] == addr[ADDR_W-1:IDX_W]);
endmodule

// File: rtl/coh_msg_apply.sv
module coh_msg_apply
  import coh_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        kind,
  input  logic [1:0]        fill_proto,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              match,
  input  cst_t              cur,
  input  logic [DATA_W-1:0] cur_data,
  output logic              upd,
  output logic              set_tag,
  output cst_t              nxt,
  output logic [DATA_W-1:0] nxt_data,
  output logic              out_need,
  output logic [1:0]        okind
);
  logic live;
  assign live = match && !cur.wbp;

  always_comb begin
    upd      = 1'b0;
    set_tag  = 1'b0;
    nxt      = cur;
    nxt_data = cur_data;
    out_need = 1'b0;
    okind    = OK_ACK;
    case (kind)
      MK_FILL: begin
        upd      = 1'b1;
        set_tag  = 1'b1;
        nxt      = '{valid: 1'b1, proto: fill_proto, dirty: 1'b0, wbp: 1'b0};
        nxt_data = fill_data;
      end
      MK_WBACK: if (match && cur.wbp) begin
        upd = 1'b1;
        nxt = '{valid: 1'b1, proto: P_BASE, dirty: 1'b0, wbp: 1'b0};
      end
      MK_DN_MW: if (live && cur.proto == P_MIG) begin
        upd      = 1'b1;
        nxt      = demote(cur, P_WP);
        out_need = 1'b1;
        okind    = cur.dirty ? OK_VAL : OK_ACK;
      end
      MK_DN_WB: if (live && cur.proto == P_WP) begin
        upd      = 1'b1;
        nxt      = demote(cur, P_BASE);
        out_need = 1'b1;
      end
      MK_DN_MB: if (live && cur.proto == P_MIG) begin
        upd      = 1'b1;
        nxt      = demote(demote(cur, P_WP), P_BASE);
        out_need = 1'b1;
        okind    = cur.dirty ? OK_VAL : OK_ACK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/coh_cell_ctrl.sv
module coh_cell_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [1:0]        ins_op,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [DATA_W-1:0] ins_wdata,
  output logic              rep_valid,
  input  logic              rep_ready,
  output logic              rep_is_data,
  output logic [DATA_W-1:0] rep_data,
  input  logic              mem_valid,
  output logic              mem_ready,
  input  logic [2:0]        mem_kind,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [1:0]        mem_proto,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [ADDR_W-1:0] ev_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  localparam int NCELL = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int NPORT = 3;   // 0 instruction, 1 memory, 2 eviction

  cst_t [NCELL-1:0]              st;
  logic [NCELL-1:0][TAG_W-1:0]   tags;
  logic [NCELL-1:0][DATA_W-1:0]  dat;

  logic [ADDR_W-1:0] lk_addr  [NPORT];
  logic              lk_match [NPORT];
  cst_t              lk_cst   [NPORT];
  logic [DATA_W-1:0] lk_data  [NPORT];

  assign lk_addr[0] = ins_addr;
  assign lk_addr[1] = mem_addr;
  assign lk_addr[2] = ev_addr;

  for (genvar g = 0; g < NPORT; g++) begin : g_lk
    coh_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_lk (
      .addr(lk_addr[g]), .st(st), .tags(tags), .dat(dat),
      .match(lk_match[g]), .cur(lk_cst[g]), .cur_data(lk_data[g])
    );
  end

  // Memory message decode
  logic              ma_upd, ma_set_tag, ma_out_need;
  cst_t              ma_nxt;
  logic [DATA_W-1:0] ma_nxt_data;
  logic [1:0]        ma_okind;

  coh_msg_apply #(.DATA_W(DATA_W)) u_ma (
    .kind(mem_kind), .fill_proto(mem_proto), .fill_data(mem_data),
    .match(lk_match[1]), .cur(lk_cst[1]), .cur_data(lk_data[1]),
    .upd(ma_upd), .set_tag(ma_set_tag), .nxt(ma_nxt), .nxt_data(ma_nxt_data),
    .out_need(ma_out_need), .okind(ma_okind)
  );

  // Named internal events
  logic ins_ok, ins_pend, ev_live, ev_wb, ev_purge;
  assign ins_ok   = op_permit(ins_op, lk_match[0], lk_cst[0]);
  assign ins_pend = lk_match[0] && lk_cst[0].wbp;
  assign ev_live  = lk_match[2] && !lk_cst[2].wbp && (lk_cst[2].proto == P_BASE);
  assign ev_wb    = ev_live && lk_cst[2].dirty;
  assign ev_purge = ev_live && !lk_cst[2].dirty;

  // Handshakes, one action per cycle: memory > eviction > instruction
  assign mem_ready   = mem_valid && (!ma_out_need || out_ready);
  assign ev_ready    = ev_valid && !mem_valid && (!ev_wb || out_ready);
  assign rep_valid   = ins_valid && !mem_valid && !ev_valid && ins_ok;
  assign ins_ready   = rep_valid && rep_ready;
  assign rep_is_data = (ins_op == OP_LOAD);
  assign rep_data    = (ins_op == OP_LOAD) ? lk_data[0] : '0;

  assign out_valid = mem_valid ? ma_out_need : (ev_valid && ev_wb);
  assign out_kind  = mem_valid ? ma_okind : OK_WBB;
  assign out_addr  = mem_valid ? mem_addr : ev_addr;
  assign out_data  = mem_valid ? lk_data[1] : lk_data[2];

  logic [IDX_W-1:0] mi, ei, ii;
  assign mi = mem_addr[IDX_W-1:0];
  assign ei = ev_addr[IDX_W-1:0];
  assign ii = ins_addr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= '0;
      tags <= '0;
      dat  <= '0;
    end else if (mem_ready) begin
      if (ma_upd) begin
        st[mi]  <= ma_nxt;
        dat[mi] <= ma_nxt_data;
        if (ma_set_tag) tags[mi] <= mem_addr[ADDR_W-1:IDX_W];
      end
    end else if (ev_ready) begin
      if (ev_wb)    st[ei].wbp <= 1'b1;
      if (ev_purge) st[ei]     <= '0;
    end else if (ins_ready && ins_op == OP_STORE) begin
      st[ii].dirty <= 1'b1;
      dat[ii]      <= ins_wdata;
    end
  end
endmodule

// File: rtl/coh_cell_ctrl_chk.sv
module coh_cell_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ins_ready,
  input logic [1:0] ins_op,
  input logic       rep_valid,
  input logic       rep_ready,
  input logic       rep_is_data,
  input logic       mem_valid,
  input logic       mem_ready,
  input logic       ev_valid,
  input logic       ev_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       ins_pend
);
  assert_msg_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (!ins_ready && !ev_ready));

  assert_ev_over_ins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !ins_ready);

  assert_pend_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ins_pend |-> !ins_ready);

  assert_backpressure_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (!mem_ready && !ev_ready));

  assert_retire_handshake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> (rep_valid && rep_ready));

  assert_load_reply_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && ins_op == 2'd0) |-> rep_is_data);
endmodule

bind coh_cell_ctrl coh_cell_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ins_ready(ins_ready), .ins_op(ins_op),
  .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_is_data(rep_is_data),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .ev_valid(ev_valid),
  .ev_ready(ev_ready), .out_valid(out_valid), .out_ready(out_ready),
  .ins_pend(ins_pend)
);

// File: tb/sim_coh_cell_ctrl.sv
module sim_coh_cell_ctrl;
  localparam int AW = 6;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 0, rep_ready = 1, mem_valid = 0, ev_valid = 0, out_ready = 1;
  logic [1:0] ins_op = 0, mem_proto = 0;
  logic [2:0] mem_kind = 0;
  logic [AW-1:0] ins_addr = 0, mem_addr = 0, ev_addr = 0;
  logic [DW-1:0] ins_wdata = 0, mem_data = 0;
  logic ins_ready, rep_valid, rep_is_data, mem_ready, ev_ready, out_valid;
  logic [DW-1:0] rep_data, out_data;
  logic [1:0] out_kind;
  logic [AW-1:0] out_addr;

  always #10 clk = ~clk;

  coh_cell_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_op(ins_op), .ins_addr(ins_addr), .ins_wdata(ins_wdata),
    .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_is_data(rep_is_data),
    .rep_data(rep_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_kind(mem_kind), .mem_addr(mem_addr), .mem_proto(mem_proto),
    .mem_data(mem_data), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_addr(ev_addr), .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_addr(out_addr), .out_data(out_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // channels, codes, protocols, outgoing kinds
  localparam logic [1:0] I = 0, M = 1, E = 2;
  localparam logic [2:0] L = 0, S = 1, C = 2, Q = 3;
  localparam logic [2:0] FI = 0, WA = 1, MW = 2, WB = 3, MB = 4;
  localparam logic [1:0] PB = 0, PW = 1, PM = 2;
  localparam logic [1:0] KW = 0, KA = 1, KV = 2;

  typedef struct packed {
    logic [1:0] ch;  logic [2:0] code; logic [5:0] addr; logic [7:0] dat;
    logic [1:0] pro; logic acc; logic [7:0] rd; logic ov; logic [1:0] ok;
    logic [7:0] od;  logic [3:0] req;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t TBL [NV] = '{
    '{I, C, 6'h01, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 3},  // R3 uncached
    '{I, Q, 6'h01, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 4},  // R4 uncached
    '{I, L, 6'h01, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 1},  // R1 miss
    '{M, FI, 6'h01, 8'h11, PB, 1, 8'h00, 0, KA, 8'h00, 12}, // R12
    '{I, L, 6'h01, 8'h00, PB, 1, 8'h11, 0, KA, 8'h00, 1},  // R1 hit
    '{I, Q, 6'h01, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 4},  // R4 clean Base
    '{I, C, 6'h01, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 3},  // R3 clean
    '{I, S, 6'h01, 8'h22, PB, 1, 8'h00, 0, KA, 8'h00, 2},  // R2
    '{I, L, 6'h01, 8'h00, PB, 1, 8'h22, 0, KA, 8'h00, 2},  // R2 data
    '{I, C, 6'h01, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 3},  // R3 dirty Base
    '{I, Q, 6'h01, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 4},  // R4 dirty
    '{I, L, 6'h09, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 1},  // R1 tag miss
    '{E, 0, 6'h01, 8'h00, PB, 1, 8'h00, 1, KW, 8'h22, 7},  // R7 writeback
    '{I, L, 6'h01, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 7},  // R7 stall
    '{I, C, 6'h01, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 7},  // R7 stall
    '{M, WA, 6'h01, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 7}, // R7 ack
    '{I, Q, 6'h01, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 7},  // R7 clean Base
    '{I, L, 6'h01, 8'h00, PB, 1, 8'h22, 0, KA, 8'h00, 7},  // R7 data kept
    '{E, 0, 6'h01, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 6},  // R6 purge
    '{I, L, 6'h01, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 6},  // R6 uncached
    '{I, C, 6'h01, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 6},  // R6
    '{M, FI, 6'h02, 8'h33, PW, 1, 8'h00, 0, KA, 8'h00, 12}, // R12 WP
    '{I, Q, 6'h02, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 4},  // R4 clean WP
    '{I, S, 6'h02, 8'h34, PB, 1, 8'h00, 0, KA, 8'h00, 2},  // R2
    '{I, C, 6'h02, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 3},  // R3 dirty WP
    '{E, 0, 6'h02, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 6},  // R6 ignored on WP
    '{I, L, 6'h02, 8'h00, PB, 1, 8'h34, 0, KA, 8'h00, 6},  // R6 unchanged
    '{M, WB, 6'h02, 8'h00, PB, 1, 8'h00, 1, KA, 8'h00, 10}, // R10
    '{I, C, 6'h02, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 10}, // R10 dirty Base
    '{E, 0, 6'h02, 8'h00, PB, 1, 8'h00, 1, KW, 8'h34, 10}, // R10 now Base
    '{M, WA, 6'h02, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 7}, // R7
    '{M, FI, 6'h03, 8'h44, PM, 1, 8'h00, 0, KA, 8'h00, 12}, // R12 Mig
    '{I, S, 6'h03, 8'h45, PB, 1, 8'h00, 0, KA, 8'h00, 2},  // R2
    '{I, C, 6'h03, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 3},  // R3 dirty Mig
    '{M, MW, 6'h03, 8'h00, PB, 1, 8'h00, 1, KV, 8'h45, 9}, // R9 dirty
    '{I, Q, 6'h03, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 9},  // R9 clean WP
    '{I, C, 6'h03, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 9},  // R9 clean
    '{M, MW, 6'h03, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 9}, // R9 not Mig
    '{M, WB, 6'h03, 8'h00, PB, 1, 8'h00, 1, KA, 8'h00, 10}, // R10
    '{I, Q, 6'h03, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 10}, // R10 clean Base
    '{M, FI, 6'h04, 8'h55, PM, 1, 8'h00, 0, KA, 8'h00, 12}, // R12
    '{I, S, 6'h04, 8'h56, PB, 1, 8'h00, 0, KA, 8'h00, 2},  // R2
    '{M, MB, 6'h04, 8'h00, PB, 1, 8'h00, 1, KV, 8'h56, 11}, // R11 dirty
    '{I, Q, 6'h04, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 11}, // R11 clean Base
    '{I, L, 6'h04, 8'h00, PB, 1, 8'h56, 0, KA, 8'h00, 11}, // R11 data
    '{M, FI, 6'h05, 8'h66, PM, 1, 8'h00, 0, KA, 8'h00, 12}, // R12
    '{M, MB, 6'h05, 8'h00, PB, 1, 8'h00, 1, KA, 8'h00, 11}, // R11 clean
    '{I, Q, 6'h05, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 11}, // R11
    '{M, MB, 6'h0C, 8'h00, PB, 1, 8'h00, 0, KA, 8'h00, 11}, // R11 miss
    '{I, L, 6'h0D, 8'h00, PB, 0, 8'h00, 0, KA, 8'h00, 1}   // R1 tag miss
  };

  task automatic idle();
    ins_valid = 0; mem_valid = 0; ev_valid = 0;
  endtask

  task automatic drive(input logic [1:0] ch, input logic [2:0] code,
                       input logic [5:0] a, input logic [7:0] d, input logic [1:0] p);
    case (ch)
      I: begin ins_valid = 1; ins_op = code[1:0]; ins_addr = a; ins_wdata = d; end
      M: begin mem_valid = 1; mem_kind = code; mem_addr = a; mem_data = d; mem_proto = p; end
      default: begin ev_valid = 1; ev_addr = a; end
    endcase
  endtask

  task automatic run_vec(input vec_t v);
    string r;
    logic acc;
    @(negedge clk);
    idle();
    drive(v.ch, v.code, v.addr, v.dat, v.pro);
    #2;
    r = $sformatf("R%0d", v.req);
    acc = (v.ch == I) ? ins_ready : (v.ch == M) ? mem_ready : ev_ready;
    chk(acc == v.acc, r, acc, v.acc);
    if (v.ch == I && v.acc && v.code == L) chk(rep_data == v.rd, r, rep_data, v.rd);
    chk(out_valid == v.ov, r, out_valid, v.ov);
    if (v.ov) begin
      chk(out_kind == v.ok, r, out_kind, v.ok);
      chk(out_addr == v.addr, r, out_addr, v.addr);
      if (v.ok != KA) chk(out_data == v.od, r, out_data, v.od);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R13 reset state
    #2;
    chk(out_valid == 0 && rep_valid == 0, "R13", {out_valid, rep_valid}, 0);
    for (int k = 0; k < NV; k++) run_vec(TBL[k]);

    // R8 message beats instruction in the same cycle
    @(negedge clk); idle();
    drive(I, C, 6'h06, 0, PB); drive(M, FI, 6'h06, 8'h77, PW); #2;
    chk(mem_ready == 1, "R8", mem_ready, 1);
    chk(ins_ready == 0 && rep_valid == 0, "R8", {ins_ready, rep_valid}, 0);
    @(negedge clk); idle(); drive(I, L, 6'h06, 0, PB); #2;
    chk(ins_ready == 1 && rep_data == 8'h77, "R8", rep_data, 8'h77);
    // R8 eviction beats instruction
    @(negedge clk); idle(); drive(E, 0, 6'h07, 0, PB); drive(I, L, 6'h04, 0, PB); #2;
    chk(ev_ready == 1 && ins_ready == 0, "R8", {ev_ready, ins_ready}, 2);

    // R5 reply back-pressure
    @(negedge clk); idle(); rep_ready = 0; drive(I, L, 6'h04, 0, PB); #2;
    chk(rep_valid == 1 && ins_ready == 0, "R5", {rep_valid, ins_ready}, 2);
    @(negedge clk); idle(); drive(I, S, 6'h04, 8'h99, PB); #2;
    chk(ins_ready == 0, "R5", ins_ready, 0);
    @(negedge clk); idle(); rep_ready = 1; drive(I, L, 6'h04, 0, PB); #2;
    chk(ins_ready == 1 && rep_data == 8'h56, "R5", rep_data, 8'h56);

    // R14 outgoing back-pressure
    @(negedge clk); idle(); drive(M, FI, 6'h07, 8'h88, PM);
    @(negedge clk); idle(); out_ready = 0; drive(M, MB, 6'h07, 0, PB); #2;
    chk(out_valid == 1 && mem_ready == 0, "R14", {out_valid, mem_ready}, 2);
    @(negedge clk); out_ready = 1; #2;
    chk(mem_ready == 1 && out_kind == KA, "R14", {mem_ready, out_kind}, 5);
    @(negedge clk); idle(); drive(I, Q, 6'h07, 0, PB); #2;
    chk(ins_ready == 0, "R14", ins_ready, 0);

    // R13 reset clears cells
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); rst_n = 1; drive(I, L, 6'h04, 0, PB); #2;
    chk(rep_valid == 0 && ins_ready == 0, "R13", {rep_valid, ins_ready}, 0);
    @(negedge clk); idle(); drive(I, C, 6'h04, 0, PB); #2;
    chk(ins_ready == 1, "R13", ins_ready, 1);
    @(negedge clk); idle(); #2;
    chk(out_valid == 0, "R13", out_valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule